// File: doc/BRIEF.md
# Fault-Aware Issue Slot Reassigner

This block decides, inside one clock, which issue slot of a multi-issue execute stage each waiting instruction will use. Every instruction is described by an identifier word. The word holds one bit for each functional-unit component the instruction needs, a pending flag and a dependency flag. Every issue slot is described by a status word. The status word holds that slot's per-component fault flags and an occupied flag. The block matches the two with a greedy first-fit search. Each pending instruction, taken in index order, goes to the lowest-numbered slot that is still free and whose needed components are all fault-free.

Two identifier tables (A and B) are handled in the same cycle by two chained search passes. Pass B sees the slots that pass A has just claimed. The block returns both tables with the pending flag cleared for every placed instruction. It also returns the final occupied flags and a per-slot source select for the downstream crossbar. On slots built as simple units, the multiplier component is never available.

The input side is a valid-only stream. The block accepts a request in every cycle that `in_valid` is high, so it never applies back-pressure, and it has no ready signal. The result appears one clock later with `out_valid`. Downstream logic must take each result in the cycle it is presented. When no request arrives, the last result is held.

Top module: `slot_sched`

## Requirements
- R1: Table A has priority over table B. All of table A is placed first, and table B can only use the slots left free after pass A.
- R2: A pending instruction (identifier bit 1 set) goes to the lowest-indexed slot that is not occupied and on which none of its required components is faulty. Instructions are visited from index 0 upward.
- R3: Identifier bits 10..2 name required components, with bit 2+c standing for component c. Status bit 1+c flags component c of that slot as faulty, and status bit 0 means occupied. An instruction is never placed on a slot where any required component is faulty.
- R4: On slots whose bit in COMPLEX_MASK is 0 (by default slots 2 and 3), component MUL_COMP (default 5, identifier bit 7) counts as faulty whatever the status says.
- R5: In the returned tables, the pending bit of each placed instruction is cleared. Every other identifier bit, including the dependency bit 0, is returned unchanged. An entry whose pending bit is clear is never placed.
- R6: The occupied output is the input occupied flags OR'd with the slots that received an instruction.
- R7: Each slot's 4-bit select is {0, table, source index}, with table A = 0 and B = 1. A slot that receives no instruction gets the NOP code 4'b1111.
- R8: Outputs are registered. A request sampled with `in_valid` high shows up on the outputs with `out_valid` high one clock later. A cycle without `in_valid` drops `out_valid` and holds the other outputs.
- R9: While reset is active, `out_valid` is 0, all identifiers and occupied flags are 0, and every select is NOP.
- R10: Each instruction is placed at most once and each slot takes at most one instruction. The number of cleared pending bits equals the number of newly occupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_ids_a | input | 44 | Table A identifiers, entry i at bits [11i+10:11i] |
| in_ids_b | input | 44 | Table B identifiers, same layout |
| in_status | input | 40 | Slot status, slot j at bits [10j+9:10j] |
| out_valid | output | 1 | Result present |
| out_ids_a | output | 44 | Table A with pending bits updated |
| out_ids_b | output | 44 | Table B with pending bits updated |
| out_occupied | output | 4 | Final occupied flag per slot |
| out_sel | output | 16 | Crossbar select per slot, slot j at bits [4j+3:4j] |

## Verification
Every result of this block is due exactly one rising edge after the request edge. This applies to the updated tables, the occupied flags, the selects and `out_valid`. The bench drives each request on a falling edge and computes the expected result from its own model at that moment. It compares the outputs on the next falling edge, after exactly one register stage. Directed cases with hand-worked select and occupancy values are sampled just after that same rising edge. Idle cycles are compared against the held previous result.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int ID_DEP_BIT  = 0;
  localparam int ID_PEND_BIT = 1;
  localparam int ID_COMP_LSB = 2;
  localparam int ST_OCC_BIT  = 0;
  localparam int ST_COMP_LSB = 1;

  typedef enum logic {
    TABLE_A = 1'b0,
    TABLE_B = 1'b1
  } table_e;
endpackage

// File: rtl/slot_health.sv
module slot_health
  import slot_pkg::*;
#(
  parameter int NISSUE = 4,
  parameter int NCOMP = 9,
  parameter int MUL_COMP = 5,
  parameter logic [NISSUE-1:0] COMPLEX_MASK = 4'b0011,
  localparam int ST_W = NCOMP + 1
) (
  input  logic [NISSUE*ST_W-1:0]  status,
  output logic [NISSUE*NCOMP-1:0] unavail,
  output logic [NISSUE-1:0]       occ
);
  localparam logic [NCOMP-1:0] MUL_BIT = NCOMP'(1) << MUL_COMP;

  for (genvar g = 0; g < NISSUE; g++) begin : g_slot
    logic [NCOMP-1:0] fault;
    assign fault  = status[g*ST_W+ST_COMP_LSB +: NCOMP];
    assign occ[g] = status[g*ST_W+ST_OCC_BIT];
    if (COMPLEX_MASK[g]) begin : g_cplx
      assign unavail[g*NCOMP +: NCOMP] = fault;
    end else begin : g_simple
      assign unavail[g*NCOMP +: NCOMP] = fault | MUL_BIT;
    end
  end
endmodule

// File: rtl/slot_fit_pass.sv
module slot_fit_pass
  import slot_pkg::*;
#(
  parameter int NISSUE = 4,
  parameter int NCOMP = 9,
  parameter logic BANK = 1'b0,
  localparam int ID_W = NCOMP + 2,
  localparam int IDX_W = $clog2(NISSUE),
  localparam int SEL_W = IDX_W + 2
) (
  input  logic [NISSUE*ID_W-1:0]  ids_in,
  input  logic [NISSUE*NCOMP-1:0] unavail,
  input  logic [NISSUE-1:0]       occ_in,
  input  logic [NISSUE*SEL_W-1:0] sel_in,
  output logic [NISSUE*ID_W-1:0]  ids_out,
  output logic [NISSUE-1:0]       occ_out,
  output logic [NISSUE*SEL_W-1:0] sel_out
);
  logic [NCOMP-1:0] need;
  logic             done;

  always_comb begin
    ids_out = ids_in;
    occ_out = occ_in;
    sel_out = sel_in;
    need    = '0;
    done    = 1'b0;
    for (int i = 0; i < NISSUE; i++) begin
      need = ids_in[i*ID_W+ID_COMP_LSB +: NCOMP];
      done = !ids_in[i*ID_W+ID_PEND_BIT];
      for (int j = 0; j < NISSUE; j++) begin
        if (!done && !occ_out[j] && ((need & unavail[j*NCOMP +: NCOMP]) == '0)) begin
          occ_out[j]                    = 1'b1;
          ids_out[i*ID_W+ID_PEND_BIT]   = 1'b0;
          sel_out[j*SEL_W +: SEL_W]     = {1'b0, BANK, IDX_W'(i)};
          done                          = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_pkg::*;
#(
  parameter int NISSUE = 4,
  parameter int NCOMP = 9,
  parameter int MUL_COMP = 5,
  parameter logic [NISSUE-1:0] COMPLEX_MASK = 4'b0011,
  localparam int ID_W = NCOMP + 2,
  localparam int ST_W = NCOMP + 1,
  localparam int SEL_W = $clog2(NISSUE) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NISSUE*ID_W-1:0]  in_ids_a,
  input  logic [NISSUE*ID_W-1:0]  in_ids_b,
  input  logic [NISSUE*ST_W-1:0]  in_status,
  output logic                    out_valid,
  output logic [NISSUE*ID_W-1:0]  out_ids_a,
  output logic [NISSUE*ID_W-1:0]  out_ids_b,
  output logic [NISSUE-1:0]       out_occupied,
  output logic [NISSUE*SEL_W-1:0] out_sel
);
  logic [NISSUE*NCOMP-1:0] unavail;
  logic [NISSUE-1:0]       status_occ;
  logic [NISSUE-1:0]       occ_mid, occ_fin;
  logic [NISSUE*SEL_W-1:0] sel_mid, sel_fin;
  logic [NISSUE*ID_W-1:0]  ids_a_nx, ids_b_nx;

  slot_health #(
    .NISSUE(NISSUE), .NCOMP(NCOMP), .MUL_COMP(MUL_COMP), .COMPLEX_MASK(COMPLEX_MASK)
  ) u_health (
    .status(in_status), .unavail(unavail), .occ(status_occ)
  );

  slot_fit_pass #(.NISSUE(NISSUE), .NCOMP(NCOMP), .BANK(TABLE_A)) u_pass_a (
    .ids_in(in_ids_a), .unavail(unavail), .occ_in(status_occ), .sel_in('1),
    .ids_out(ids_a_nx), .occ_out(occ_mid), .sel_out(sel_mid)
  );

  slot_fit_pass #(.NISSUE(NISSUE), .NCOMP(NCOMP), .BANK(TABLE_B)) u_pass_b (
    .ids_in(in_ids_b), .unavail(unavail), .occ_in(occ_mid), .sel_in(sel_mid),
    .ids_out(ids_b_nx), .occ_out(occ_fin), .sel_out(sel_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ids_a    <= '0;
      out_ids_b    <= '0;
      out_occupied <= '0;
      out_sel      <= '1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ids_a    <= ids_a_nx;
        out_ids_b    <= ids_b_nx;
        out_occupied <= occ_fin;
        out_sel      <= sel_fin;
      end
    end
  end
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
  import slot_pkg::*;
#(
  parameter int NISSUE = 4,
  parameter int NCOMP = 9,
  localparam int ID_W = NCOMP + 2,
  localparam int SEL_W = $clog2(NISSUE) + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [NISSUE*ID_W-1:0]  in_ids_a,
  input logic [NISSUE*ID_W-1:0]  in_ids_b,
  input logic [NISSUE-1:0]       status_occ,
  input logic                    out_valid,
  input logic [NISSUE*ID_W-1:0]  out_ids_a,
  input logic [NISSUE*ID_W-1:0]  out_ids_b,
  input logic [NISSUE-1:0]       out_occupied,
  input logic [NISSUE*SEL_W-1:0] out_sel
);
  function automatic logic [NISSUE*ID_W-1:0] pend_mask();
    logic [NISSUE*ID_W-1:0] m;
    m = '0;
    for (int i = 0; i < NISSUE; i++) m[i*ID_W+ID_PEND_BIT] = 1'b1;
    return m;
  endfunction
  localparam logic [NISSUE*ID_W-1:0] PMASK = pend_mask();

  logic [2*NISSUE-1:0] pend_in, pend_out;
  for (genvar g = 0; g < NISSUE; g++) begin : g_pend
    assign pend_in[g]         = in_ids_a[g*ID_W+ID_PEND_BIT];
    assign pend_in[g+NISSUE]  = in_ids_b[g*ID_W+ID_PEND_BIT];
    assign pend_out[g]        = out_ids_a[g*ID_W+ID_PEND_BIT];
    assign pend_out[g+NISSUE] = out_ids_b[g*ID_W+ID_PEND_BIT];
  end

  a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sel) && $stable(out_occupied)));

  a_r6_keep_occ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_occupied & $past(status_occ)) == $past(status_occ)));

  a_r5_no_new_pending: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((pend_out & ~$past(pend_in)) == '0));

  a_r5_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_ids_a & ~PMASK) == ($past(in_ids_a) & ~PMASK)) &&
                  ((out_ids_b & ~PMASK) == ($past(in_ids_b) & ~PMASK))));

  a_r10_balance: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (($countones($past(pend_in)) - $countones(pend_out)) ==
                  ($countones(out_occupied) - $countones($past(status_occ)))));

  for (genvar j = 0; j < NISSUE; j++) begin : g_sel
    a_r7_routed_is_occ: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sel[j*SEL_W+SEL_W-1]) |-> out_occupied[j]);
  end
endmodule

bind slot_sched slot_sched_chk #(.NISSUE(NISSUE), .NCOMP(NCOMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ids_a(in_ids_a),
  .in_ids_b(in_ids_b), .status_occ(status_occ), .out_valid(out_valid),
  .out_ids_a(out_ids_a), .out_ids_b(out_ids_b), .out_occupied(out_occupied),
  .out_sel(out_sel)
);

// File: tb/tb_slot_sched.sv
module tb_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NC = 9;
  localparam int IW = 11;
  localparam int SW = 10;
  localparam int LW = 4;
  localparam logic [N-1:0] CPLX = 4'b0011;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [N*IW-1:0] in_ids_a = '0, in_ids_b = '0;
  logic [N*SW-1:0] in_status = '0;
  logic out_valid;
  logic [N*IW-1:0] out_ids_a, out_ids_b;
  logic [N-1:0] out_occupied;
  logic [N*LW-1:0] out_sel;

  logic            e_valid = 1'b0;
  logic [N*IW-1:0] e_a = '0, e_b = '0;
  logic [N-1:0]    e_occ = '0;
  logic [N*LW-1:0] e_sel = '1;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_sched dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ids_a(in_ids_a),
    .in_ids_b(in_ids_b), .in_status(in_status), .out_valid(out_valid),
    .out_ids_a(out_ids_a), .out_ids_b(out_ids_b), .out_occupied(out_occupied),
    .out_sel(out_sel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model: builds the expected result from the requirement text.
  task automatic model(input logic [N*IW-1:0] a, input logic [N*IW-1:0] b,
                       input logic [N*SW-1:0] st);
    logic [N*IW-1:0] tab [2];
    bit taken [N];
    int slot_src [N];
    tab[0] = a; tab[1] = b;
    for (int j = 0; j < N; j++) begin
      taken[j] = st[j*SW] == 1'b1;
      slot_src[j] = -1;
    end
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < N; i++) begin
        if (tab[t][i*IW+1]) begin
          int pick;
          pick = -1;
          for (int j = N-1; j >= 0; j--) begin
            bit ok;
            ok = !taken[j];
            for (int c = 0; c < NC; c++) begin
              bit bad;
              bad = st[j*SW+1+c] || (c == 5 && !CPLX[j]);
              if (tab[t][i*IW+2+c] && bad) ok = 0;
            end
            if (ok) pick = j;
          end
          if (pick >= 0) begin
            taken[pick] = 1;
            slot_src[pick] = t*4 + i;
            tab[t][i*IW+1] = 1'b0;
          end
        end
      end
    end
    e_a = tab[0]; e_b = tab[1];
    for (int j = 0; j < N; j++) begin
      e_occ[j] = taken[j];
      e_sel[j*LW +: LW] = (slot_src[j] < 0) ? 4'hF : LW'(slot_src[j]);
    end
  endtask

  // Compare on the falling edge, then drive the next request.
  task automatic step(input logic v, input logic [N*IW-1:0] a,
                      input logic [N*IW-1:0] b, input logic [N*SW-1:0] st);
    @(negedge clk);
    chk("R8 out_valid", 64'(out_valid), 64'(e_valid));
    chk("R5 out_ids_a", 64'(out_ids_a), 64'(e_a));
    chk("R5 out_ids_b", 64'(out_ids_b), 64'(e_b));
    chk("R6 out_occupied", 64'(out_occupied), 64'(e_occ));
    chk("R7 out_sel", 64'(out_sel), 64'(e_sel));
    in_valid = v; in_ids_a = a; in_ids_b = b; in_status = st;
    if (v) model(a, b, st);
    e_valid = v;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  function automatic logic [N*IW-1:0] one(input int idx, input logic [IW-1:0] id);
    logic [N*IW-1:0] r;
    r = '0;
    r[idx*IW +: IW] = id;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 valid", 64'(out_valid), 64'd0);
    chk("R9 sel", 64'(out_sel), 64'hFFFF);
    chk("R9 occ", 64'(out_occupied), 64'd0);
    chk("R9 ids", 64'(out_ids_a | out_ids_b), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: component 1 plus select mux, pending, free slots -> slot 0
    step(1, one(0, 11'b00000001110), '0, '0);
    after_edge();
    chk("R2 sel", 64'(out_sel), 64'hFFF0);
    chk("R2 ids", 64'(out_ids_a[IW-1:0]), 64'h00C);

    // R3: slot0 comp1 faulty, slot1 comp0 faulty -> slot 2
    step(1, one(0, 11'b00000001110), '0, 40'h0_0000_0204 | (40'h2 << SW));
    after_edge();
    chk("R3 sel", 64'(out_sel), 64'hF0FF);
    chk("R3 occ", 64'(out_occupied), 64'h4);

    // R4: multiplier op, complex slots busy -> no placement on simple slots
    step(1, one(0, 11'h086), '0, 40'h1 | (40'h1 << SW));
    after_edge();
    chk("R4 sel", 64'(out_sel), 64'hFFFF);
    chk("R4 pending kept", 64'(out_ids_a[IW-1:0]), 64'h086);

    // R1: table A entry 1 beats table B entry 0
    step(1, one(1, 11'h006), one(0, 11'h006), '0);
    after_edge();
    chk("R1 sel", 64'(out_sel), 64'hFF41);
    chk("R1 occ", 64'(out_occupied), 64'h3);

    // R10: both tables full, A takes every slot, B stays pending
    step(1, {4{11'h006}}, {4{11'h006}}, '0);
    after_edge();
    chk("R10 sel", 64'(out_sel), 64'h3210);
    chk("R10 b pending", 64'(out_ids_b), 64'({4{11'h006}}));

    // R5: dependency bit kept, non-pending entry ignored
    step(1, one(0, 11'h00F) | one(1, 11'h004), '0, '0);
    after_edge();
    chk("R5 dep kept", 64'(out_ids_a[2*IW-1:0]), 64'({11'h004, 11'h00D}));
    chk("R5 sel", 64'(out_sel), 64'hFFF0);

    // R8: idle cycle holds outputs
    step(0, '0, '0, '0);
    after_edge();
    chk("R8 hold sel", 64'(out_sel), 64'hFFF0);

    for (int k = 0; k < 3000; k++) begin
      logic [N*IW-1:0] ra, rb;
      logic [N*SW-1:0] rs;
      for (int i = 0; i < N; i++) begin
        ra[i*IW +: IW] = IW'($urandom & $urandom & $urandom);
        rb[i*IW +: IW] = IW'($urandom & $urandom & $urandom);
        ra[i*IW+1] = ($urandom_range(0, 3) != 0);
        rb[i*IW+1] = ($urandom_range(0, 3) != 0);
        rs[i*SW +: SW] = SW'($urandom & $urandom & $urandom);
      end
      step($urandom_range(0, 3) != 0, ra, rb, rs);
    end
    step(0, '0, '0, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule